// File: doc/BRIEF.md
# Compact 32-bit substitution-permutation cipher core

This block encrypts one 32-bit word under a 32-bit key with a shrunken Rijndael-style round structure. The state is a single four-byte column. Each round substitutes bytes, rotates the column, mixes it over GF(2^8) and adds a round key. The round key is derived on the fly from the previous one. The plaintext arrives as two 16-bit halves, each written by its own load strobe. A start pulse launches the encryption. The core then iterates one round per clock until the ciphertext register is written and the completion flag rises.

The core runs on its own fast clock. A slower host writes the halves and the key, pulses start, and later reads the ciphertext once the completion flag is seen. While a run is in progress, the core ignores loads, key changes and further start pulses, so the host cannot corrupt an encryption in flight.

Top module: `rijndael32_core`

## Requirements
- R1: After reset, or when reset is asserted mid-run, `busy` and `done` are 0 and `dout` is 0.
- R2: While idle, `load_lo` copies `din` into plaintext bits 15:0 and `load_hi` copies `din` into bits 31:16. A start in a later cycle uses the assembled word.
- R3: A `start` seen while idle makes `busy` 1 and `done` 0 from the next cycle. At that edge it captures `key` and whitens the state as plaintext XOR key.
- R4: `busy` stays high for exactly 10 cycles. `done` rises on the edge that drops `busy`, and the two are never high together.
- R5: Rounds 1 to 9 apply substitution, rotation, mixing and round-key XOR. Round 10 omits mixing. Byte i of a word is bits 8i+7:8i.
- R6: Substitution maps every byte through the standard AES S-box (GF(2^8) inverse under 0x11B followed by the affine map with constant 0x63).
- R7: Rotation sets output byte i to input byte (i+1) mod 4. Mixing multiplies the column by the circulant matrix with first row {2,3,1,1}, so that b0 = 2a0^3a1^a2^a3.
- R8: Round key r is the previous key XOR (rotated, substituted previous key, with rc_r XORed into byte 0). Here rc_1 = 0x01 and each later rc is the previous one doubled in GF(2^8).
- R9: `done` and `dout` hold their values until the next accepted start. `dout` changes only on the completing edge.
- R10: While `busy`, `load_lo`, `load_hi`, `start` and changes on `key` have no effect on the result in flight or on the stored plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast round clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Plaintext half to load |
| load_lo | input | 1 | Write `din` into plaintext bits 15:0 |
| load_hi | input | 1 | Write `din` into plaintext bits 31:16 |
| key | input | 32 | Cipher key, captured at start |
| start | input | 1 | Begin an encryption |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | Ciphertext valid |
| dout | output | 32 | Ciphertext register |

## Verification
A fault in the state path, the S-box, the mixing or the key schedule reaches the ports only through `dout`. It is visible on the completing edge, ten cycles after start. Because every byte diffuses through several rounds, a single wrong round corrupts almost all 32 output bits. A fault in the round counter shows earlier, as `done` rising on the wrong cycle, and that is measured cycle by cycle. Stored-plaintext corruption from loads accepted while busy surfaces only on the following run, so that run is started without reloading.

// File: rtl/rijndael32_core.sv
module rijndael32_core #(
  parameter int ROUNDS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] din,
  input  logic        load_lo,
  input  logic        load_hi,
  input  logic [31:0] key,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic [31:0] dout
);
  localparam int RW = $clog2(ROUNDS + 1);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] r, q, s;
    r = 8'h01;
    q = a;
    for (int i = 0; i < 7; i++) begin
      q = gmul(q, q);
      r = gmul(r, q);
    end
    s = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]};
    return s ^ 8'h63;
  endfunction

  function automatic logic [31:0] sub_w(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [31:0] rot_w(input logic [31:0] w);
    return {w[7:0], w[31:8]};
  endfunction

  function automatic logic [31:0] mix_w(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    a0 = w[7:0]; a1 = w[15:8]; a2 = w[23:16]; a3 = w[31:24];
    return {xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3),
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3};
  endfunction

  logic [31:0]   pt, st, rk;
  logic [RW-1:0] rnd;
  logic [7:0]    rc;

  wire        go   = start & ~busy;
  wire        last = rnd == RW'(ROUNDS);
  wire [31:0] sr   = rot_w(sub_w(st));
  wire [31:0] rk_n = rk ^ sub_w(rot_w(rk)) ^ {24'h0, rc};
  wire [31:0] st_n = (last ? sr : mix_w(sr)) ^ rk_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt   <= '0;
      st   <= '0;
      rk   <= '0;
      rnd  <= '0;
      rc   <= 8'h01;
      busy <= 1'b0;
      done <= 1'b0;
      dout <= '0;
    end else begin
      if (!busy && load_lo) pt[15:0]  <= din;
      if (!busy && load_hi) pt[31:16] <= din;
      if (go) begin
        st   <= pt ^ key;
        rk   <= key;
        rnd  <= RW'(1);
        rc   <= 8'h01;
        busy <= 1'b1;
        done <= 1'b0;
      end else if (busy) begin
        st  <= st_n;
        rk  <= rk_n;
        rc  <= xt(rc);
        rnd <= rnd + RW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          dout <= st_n;
        end
      end
    end
  end
endmodule

// File: rtl/rijndael32_chk.sv
module rijndael32_chk #(
  parameter int ROUNDS = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] dout
);
  logic [7:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start && !busy)   cnt <= '0;
    else if (busy)             cnt <= cnt + 8'd1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done); // R3
  AST_NOT_BOTH:   assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R4
  AST_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt == 8'(ROUNDS)); // R4
  AST_DONE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R9
  AST_DOUT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(dout)); // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && cnt < 8'(ROUNDS - 1) |=> busy); // R10
endmodule

bind rijndael32_core rijndael32_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .dout(dout)
);

// File: tb/test_rijndael32_core.sv
module test_rijndael32_core;
  logic clk = 0, rst_n = 0;
  logic [15:0] din = '0;
  logic load_lo = 0, load_hi = 0, start = 0;
  logic [31:0] key = '0;
  logic busy, done;
  logic [31:0] dout;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rijndael32_core i_rijndael32_core (.clk(clk), .rst_n(rst_n), .din(din), .load_lo(load_lo),
    .load_hi(load_hi), .key(key), .start(start), .busy(busy), .done(done), .dout(dout));

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] x; logic [7:0] p;
    p = 0; x = {1'b0, a};
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x[7:0];
      x = x << 1;
      if (x[8]) x ^= 9'h11b;
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] inv, s;
    inv = 0;
    for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
    s = 8'h63;
    for (int k = 0; k < 5; k++) s ^= (inv << k) | (inv >> (8 - k));
    return s;
  endfunction

  function automatic logic [7:0] byt(input logic [31:0] w, input int i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [31:0] m_rot(input logic [31:0] w);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[8*i +: 8] = byt(w, (i + 1) % 4);
    return o;
  endfunction

  function automatic logic [31:0] m_sub(input logic [31:0] w);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[8*i +: 8] = m_sbox(byt(w, i));
    return o;
  endfunction

  function automatic logic [31:0] m_mix(input logic [31:0] w);
    logic [31:0] o; logic [7:0] c;
    for (int i = 0; i < 4; i++) begin
      o[8*i +: 8] = 0;
      for (int j = 0; j < 4; j++) begin
        c = ((j - i + 4) % 4 == 0) ? 8'd2 : ((j - i + 4) % 4 == 1) ? 8'd3 : 8'd1;
        o[8*i +: 8] ^= m_mul(c, byt(w, j));
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] k);
    logic [31:0] s, rk; logic [7:0] rc;
    s = p ^ k; rk = k; rc = 8'h01;
    for (int r = 1; r <= 10; r++) begin
      rk = rk ^ m_sub(m_rot(rk)) ^ {24'h0, rc};
      rc = m_mul(rc, 8'h02);
      s = m_rot(m_sub(s));
      if (r < 10) s = m_mix(s);
      s ^= rk;
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] p);
    @(negedge clk); load_lo = 1; din = p[15:0];
    @(negedge clk); load_lo = 0; load_hi = 1; din = p[31:16];
    @(negedge clk); load_hi = 0;
  endtask

  task automatic go_wait(input logic [31:0] k, input string req);
    key = k; start = 1;
    @(negedge clk); start = 0;
    chk({req, " R3 busy after start"}, 32'(busy), 1);
    chk({req, " R3 done cleared"}, 32'(done), 0);
    repeat (9) @(negedge clk);
    chk({req, " R4 not done at 9"}, {30'b0, busy, done}, 2'b10);
    @(negedge clk);
    chk({req, " R4 done at 10"}, {30'b0, busy, done}, 2'b01);
  endtask

  localparam logic [63:0] VEC [6] = '{
    {32'h00000000, 32'h00000000}, {32'hffffffff, 32'hffffffff},
    {32'h01234567, 32'h89abcdef}, {32'hdeadbeef, 32'h00000000},
    {32'h00000000, 32'hcafef00d}, {32'h80000001, 32'h00000080}};

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset", {busy, done, dout[29:0]}, 0);
    chk("R1 reset dout", dout, 0);
    rst_n = 1;

    foreach (VEC[v]) begin
      load(VEC[v][63:32]);
      go_wait(VEC[v][31:0], "R2");
      chk("R5 R6 R7 R8 ciphertext", dout, model(VEC[v][63:32], VEC[v][31:0]));
    end

    held = dout;
    key = 32'h5a5a5a5a; din = 16'h1111;
    repeat (15) @(negedge clk);
    chk("R9 done held", 32'(done), 1);
    chk("R9 dout held", dout, held);

    load(32'h13579bdf);
    key = 32'h2468ace0; start = 1;
    @(negedge clk); start = 0;
    chk("R10 started", 32'(busy), 1);
    load_lo = 1; load_hi = 1; din = 16'hbeef; key = 32'hffff0000;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; load_lo = 0; load_hi = 0;
    repeat (7) @(negedge clk);
    chk("R10 result unaffected", dout, held);
    @(negedge clk);
    chk("R10 done", 32'(done), 1);
    chk("R10 result", dout, model(32'h13579bdf, 32'h2468ace0));

    @(negedge clk);
    go_wait(32'h0f0f0f0f, "R10 reuse");
    chk("R10 plaintext kept", dout, model(32'h13579bdf, 32'h0f0f0f0f));

    @(negedge clk); load_lo = 1; din = 16'h4444;
    @(negedge clk); load_lo = 0;
    go_wait(32'h00000001, "R2 low half only");
    chk("R2 low half", dout, model(32'h13574444, 32'h00000001));

    key = 32'h77777777; start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid-run reset", {30'b0, busy, done}, 0);
    chk("R1 mid-run reset dout", dout, 0);
    rst_n = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule